// File: doc/BRIEF.md
# Pipeline Hazard Interlock Unit

This unit decides each cycle whether a five-stage in-order pipeline may move forward. The pipeline has fetch, decode, execute, memory access and writeback stages. It has a single memory port shared by instruction fetch and data access. It has no operand bypass paths, and it resolves branches only at the end of execute. The unit looks at what occupies decode, execute and memory access. It then raises the PC hold, the decode-register hold, the execute bubble, the fetch suppress and the two memory-port grants. It computes all of these combinationally from the stage contents.

Three stall sources are merged here.

- **Port contention:** a load or store in the memory stage takes the port, so the fetch slot for that cycle is lost.
- **Operand wait:** an instruction in decode waits there while a register it reads is still going to be written by an older instruction in execute or memory access. The register file writes early and reads late in a cycle, so a producer that has reached writeback no longer blocks.
- **Branch wait:** every branch stops fetching from the time it sits in decode until it has left execute. There is no prediction.

Top module: `hazard_ctl`

## Requirements
- R1: Instruction classes are encoded on two bits: ALU = 0, LOAD = 1, STORE = 2, BRANCH = 3. A valid LOAD or STORE in the memory stage asserts `gnt_mem`, `fetch_kill` and `pc_hold` and clears `gnt_if`. `gnt_if` and `gnt_mem` are never both high.
- R2: A port conflict on its own does not hold the decode register and does not bubble execute. The instruction in decode advances, and the decode register receives an empty slot.
- R3: If a non-zero source register of a valid decode instruction equals the destination of a valid, write-enabled instruction in execute or in memory access, `pc_hold`, `ifid_hold` and `ex_bubble` are all 1.
- R4: A producer that has reached writeback no longer blocks. A dependent instruction leaves decode in the same cycle its producer is in writeback. A load followed by a dependent instruction therefore holds that instruction in decode for exactly three cycles.
- R5: Register 0 never creates a dependency. A destination whose write enable is 0 never creates a dependency.
- R6: An invalid stage (a bubble) never takes the memory port, never counts as a producer and never counts as a branch. An invalid decode slot is never stalled.
- R7: A valid BRANCH in decode or in execute asserts `fetch_kill` and `pc_hold`. The instruction that follows a branch reaches decode three cycles after the branch was in decode.
- R8: With no stall condition, all holds, bubble and suppress outputs are 0 and `gnt_if` is 1.
- R9: When several stall sources apply at once, each output is the union of what each source asserts on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_vld | input | 1 | Decode stage holds a valid instruction |
| id_cls | input | 2 | Class of the decode instruction |
| id_src | input | NSRC x REG_W | Source register numbers of the decode instruction |
| ex_vld | input | 1 | Execute stage holds a valid instruction |
| ex_cls | input | 2 | Class of the execute instruction |
| ex_rd | input | REG_W | Destination register in execute |
| ex_we | input | 1 | Execute instruction writes its destination |
| mem_vld | input | 1 | Memory stage holds a valid instruction |
| mem_cls | input | 2 | Class of the memory-stage instruction |
| mem_rd | input | REG_W | Destination register in the memory stage |
| mem_we | input | 1 | Memory-stage instruction writes its destination |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the decode register contents |
| ex_bubble | output | 1 | Load an invalid slot into execute |
| fetch_kill | output | 1 | No fetch this cycle; decode register takes an empty slot unless held |
| gnt_if | output | 1 | Memory port granted to instruction fetch |
| gnt_mem | output | 1 | Memory port granted to the memory stage |

## Verification
The hardest case to reach from the ports is overlapping stalls over time. In that case a load sits in the memory stage, holding the port, while its consumer is held in decode. The consumer must then leave decode in exactly the cycle the load reaches writeback. No single input vector shows this. The bench therefore steps a small behavioural pipeline, fed by the unit's own outputs, through a load followed by a dependent instruction, back-to-back stores, and a branch followed by an ALU instruction. Each cycle it compares which instruction occupies decode against a hand-derived occupancy table.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    CL_ALU   = 2'd0,
    CL_LOAD  = 2'd1,
    CL_STORE = 2'd2,
    CL_BR    = 2'd3
  } icls_e;
endpackage

// File: rtl/hz_dep_cmp.sv
// One source operand compared against the two in-flight producers that
// have not yet reached writeback.
module hz_dep_cmp #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             ex_vld,
  input  logic             ex_we,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             mem_vld,
  input  logic             mem_we,
  input  logic [REG_W-1:0] mem_rd,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic src_live;
  logic ex_hit;
  logic mem_hit;

  always_comb begin
    src_live = (src != ZERO_REG);
    ex_hit   = ex_vld  && ex_we  && (ex_rd  == src);
    mem_hit  = mem_vld && mem_we && (mem_rd == src);
    hit      = src_live && (ex_hit || mem_hit);
  end
endmodule

// File: rtl/hz_branch_gate.sv
// A branch stops fetching while it is in decode or execute.
module hz_branch_gate
  import hz_pkg::*;
(
  input  logic       id_vld,
  input  logic [1:0] id_cls,
  input  logic       ex_vld,
  input  logic [1:0] ex_cls,
  output logic       br_pend
);
  logic id_br;
  logic ex_br;

  always_comb begin
    id_br   = id_vld && (icls_e'(id_cls) == CL_BR);
    ex_br   = ex_vld && (icls_e'(ex_cls) == CL_BR);
    br_pend = id_br || ex_br;
  end
endmodule

// File: rtl/hz_port_arb.sv
// Single memory port: the data access wins, fetch takes the port otherwise
// unless fetch is suppressed or the PC is held for an operand wait.
module hz_port_arb
  import hz_pkg::*;
(
  input  logic       mem_vld,
  input  logic [1:0] mem_cls,
  input  logic       br_pend,
  input  logic       data_stall,
  output logic       gnt_mem,
  output logic       gnt_if,
  output logic       fetch_kill
);
  logic mem_acc;

  always_comb begin
    mem_acc    = mem_vld && ((icls_e'(mem_cls) == CL_LOAD) ||
                             (icls_e'(mem_cls) == CL_STORE));
    gnt_mem    = mem_acc;
    fetch_kill = mem_acc || br_pend;
    gnt_if     = !fetch_kill && !data_stall;
  end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic                       id_vld,
  input  logic [1:0]                 id_cls,
  input  logic [NSRC-1:0][REG_W-1:0] id_src,
  input  logic                       ex_vld,
  input  logic [1:0]                 ex_cls,
  input  logic [REG_W-1:0]           ex_rd,
  input  logic                       ex_we,
  input  logic                       mem_vld,
  input  logic [1:0]                 mem_cls,
  input  logic [REG_W-1:0]           mem_rd,
  input  logic                       mem_we,
  output logic                       pc_hold,
  output logic                       ifid_hold,
  output logic                       ex_bubble,
  output logic                       fetch_kill,
  output logic                       gnt_if,
  output logic                       gnt_mem
);
  logic [NSRC-1:0] src_hit;
  logic            data_stall;
  logic            br_pend;
  logic            kill_int;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_dep_cmp #(.REG_W(REG_W)) u_cmp (
      .src     (id_src[g]),
      .ex_vld  (ex_vld),
      .ex_we   (ex_we),
      .ex_rd   (ex_rd),
      .mem_vld (mem_vld),
      .mem_we  (mem_we),
      .mem_rd  (mem_rd),
      .hit     (src_hit[g])
    );
  end

  always_comb data_stall = id_vld && (|src_hit);

  hz_branch_gate u_br (
    .id_vld  (id_vld),
    .id_cls  (id_cls),
    .ex_vld  (ex_vld),
    .ex_cls  (ex_cls),
    .br_pend (br_pend)
  );

  hz_port_arb u_arb (
    .mem_vld    (mem_vld),
    .mem_cls    (mem_cls),
    .br_pend    (br_pend),
    .data_stall (data_stall),
    .gnt_mem    (gnt_mem),
    .gnt_if     (gnt_if),
    .fetch_kill (kill_int)
  );

  always_comb begin
    fetch_kill = kill_int;
    ifid_hold  = data_stall;
    ex_bubble  = data_stall;
    pc_hold    = data_stall || kill_int;
  end
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int REG_W = 5
) (
  input logic             id_vld,
  input logic             ex_vld,
  input logic [1:0]       ex_cls,
  input logic [REG_W-1:0] ex_rd,
  input logic             pc_hold,
  input logic             ifid_hold,
  input logic             ex_bubble,
  input logic             fetch_kill,
  input logic             gnt_if,
  input logic             gnt_mem
);
  logic known;

  always_comb begin
    known = !$isunknown({id_vld, ex_vld, ex_cls, ex_rd, pc_hold, ifid_hold,
                         ex_bubble, fetch_kill, gnt_if, gnt_mem});
    if (known) begin
      p_grant_excl_r1: assert ($onehot0({gnt_if, gnt_mem}));
      p_port_stops_fetch_r1: assert (!gnt_mem || (fetch_kill && !gnt_if));
      p_struct_keeps_id_r2: assert (!(gnt_mem && !ex_bubble) || !ifid_hold);
      p_bubble_holds_r3: assert (!ex_bubble || (ifid_hold && pc_hold));
      p_empty_id_free_r6: assert (id_vld || !ex_bubble);
      p_branch_kill_r7: assert (!(ex_vld && ex_cls == 2'd3) || fetch_kill);
      p_free_fetch_r8: assert (pc_hold || gnt_if);
    end
  end
endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_W(REG_W)) u_chk (
  .id_vld     (id_vld),
  .ex_vld     (ex_vld),
  .ex_cls     (ex_cls),
  .ex_rd      (ex_rd),
  .pc_hold    (pc_hold),
  .ifid_hold  (ifid_hold),
  .ex_bubble  (ex_bubble),
  .fetch_kill (fetch_kill),
  .gnt_if     (gnt_if),
  .gnt_mem    (gnt_mem)
);

// File: tb/sim_hazard_ctl.sv
module sim_hazard_ctl;
  localparam logic [1:0] A = 2'd0, L = 2'd1, S = 2'd2, B = 2'd3;
  localparam int NT = 16;

  // {id_vld,id_cls,src1,src0, ex_vld,ex_cls,ex_rd,ex_we, mem_vld,mem_cls,mem_rd,mem_we,
  //  exp: pc_hold,ifid_hold,ex_bubble,fetch_kill,gnt_if,gnt_mem}
  localparam logic [36:0] TBL [0:NT-1] = '{
    {1'b0,A,5'd0,5'd0, 1'b0,A,5'd0,1'b0, 1'b0,A,5'd0,1'b0, 6'b000010}, // R8 idle
    {1'b1,A,5'd4,5'd3, 1'b1,A,5'd3,1'b1, 1'b0,A,5'd0,1'b0, 6'b111000}, // R3 EX producer
    {1'b1,A,5'd4,5'd3, 1'b1,A,5'd3,1'b0, 1'b0,A,5'd0,1'b0, 6'b000010}, // R5 we low
    {1'b1,A,5'd0,5'd0, 1'b1,A,5'd0,1'b1, 1'b0,A,5'd0,1'b0, 6'b000010}, // R5 reg zero
    {1'b1,A,5'd7,5'd5, 1'b0,A,5'd0,1'b0, 1'b1,A,5'd7,1'b1, 6'b111000}, // R3 MEM producer
    {1'b1,A,5'd7,5'd5, 1'b0,A,5'd0,1'b0, 1'b1,L,5'd9,1'b1, 6'b100101}, // R2 port only
    {1'b1,A,5'd0,5'd9, 1'b0,A,5'd0,1'b0, 1'b1,L,5'd9,1'b1, 6'b111101}, // R9 port+data
    {1'b0,A,5'd0,5'd3, 1'b1,A,5'd3,1'b1, 1'b0,A,5'd0,1'b0, 6'b000010}, // R6 empty ID
    {1'b1,A,5'd0,5'd3, 1'b0,A,5'd3,1'b1, 1'b0,A,5'd0,1'b0, 6'b000010}, // R6 EX bubble
    {1'b1,B,5'd0,5'd0, 1'b0,A,5'd0,1'b0, 1'b0,A,5'd0,1'b0, 6'b100100}, // R7 branch in ID
    {1'b0,A,5'd0,5'd0, 1'b1,B,5'd0,1'b0, 1'b0,A,5'd0,1'b0, 6'b100100}, // R7 branch in EX
    {1'b0,A,5'd0,5'd0, 1'b0,A,5'd0,1'b0, 1'b0,S,5'd0,1'b0, 6'b000010}, // R6 MEM bubble
    {1'b1,A,5'd2,5'd1, 1'b0,A,5'd0,1'b0, 1'b1,S,5'd0,1'b0, 6'b100101}, // R1 store port
    {1'b0,A,5'd0,5'd0, 1'b0,B,5'd0,1'b0, 1'b0,A,5'd0,1'b0, 6'b000010}, // R6 EX bubble branch
    {1'b1,B,5'd0,5'd4, 1'b1,A,5'd4,1'b1, 1'b0,A,5'd0,1'b0, 6'b111100}, // R9 branch+data
    {1'b1,A,5'd6,5'd6, 1'b1,L,5'd6,1'b1, 1'b0,A,5'd0,1'b0, 6'b111000}  // R3 load in EX
  };
  localparam int TREQ [0:NT-1] = '{8,3,5,5,3,2,9,6,6,7,7,6,1,6,9,3};

  logic clk;
  logic rst_n;
  int   n_chk;
  int   n_err;
  bit   done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // table drive
  logic       t_id_vld, t_ex_vld, t_ex_we, t_mem_vld, t_mem_we;
  logic [1:0] t_id_cls, t_ex_cls, t_mem_cls;
  logic [4:0] t_s1, t_s0, t_ex_rd, t_mem_rd;
  logic [5:0] t_exp;
  bit         use_model;

  // behavioural pipeline model
  logic [1:0] p_cls [0:7];
  logic [4:0] p_rd [0:7];
  logic [4:0] p_s0 [0:7];
  logic [4:0] p_s1 [0:7];
  int         plen;
  int         pc;
  logic       m_id_v, m_ex_v, m_mem_v;
  logic [1:0] m_id_k, m_ex_k, m_mem_k;
  logic [4:0] m_id_s0, m_id_s1, m_id_rd, m_ex_rd, m_mem_rd;
  logic       m_ex_w, m_mem_w;
  int         m_id_i;

  logic                 id_vld, ex_vld, ex_we, mem_vld, mem_we;
  logic [1:0]           id_cls, ex_cls, mem_cls;
  logic [1:0][4:0]      id_src;
  logic [4:0]           ex_rd, mem_rd;
  logic pc_hold, ifid_hold, ex_bubble, fetch_kill, gnt_if, gnt_mem;

  always_comb begin
    if (use_model) begin
      id_vld = m_id_v;  id_cls = m_id_k;  id_src = {m_id_s1, m_id_s0};
      ex_vld = m_ex_v;  ex_cls = m_ex_k;  ex_rd = m_ex_rd;  ex_we = m_ex_w;
      mem_vld = m_mem_v; mem_cls = m_mem_k; mem_rd = m_mem_rd; mem_we = m_mem_w;
    end else begin
      id_vld = t_id_vld; id_cls = t_id_cls; id_src = {t_s1, t_s0};
      ex_vld = t_ex_vld; ex_cls = t_ex_cls; ex_rd = t_ex_rd; ex_we = t_ex_we;
      mem_vld = t_mem_vld; mem_cls = t_mem_cls; mem_rd = t_mem_rd; mem_we = t_mem_we;
    end
  end

  hazard_ctl u0 (
    .id_vld(id_vld), .id_cls(id_cls), .id_src(id_src),
    .ex_vld(ex_vld), .ex_cls(ex_cls), .ex_rd(ex_rd), .ex_we(ex_we),
    .mem_vld(mem_vld), .mem_cls(mem_cls), .mem_rd(mem_rd), .mem_we(mem_we),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .ex_bubble(ex_bubble),
    .fetch_kill(fetch_kill), .gnt_if(gnt_if), .gnt_mem(gnt_mem)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    rst_n = 1'b0;
    pc = 0;
    m_id_v = 1'b0; m_ex_v = 1'b0; m_mem_v = 1'b0;
    m_id_k = A; m_ex_k = A; m_mem_k = A;
    m_id_s0 = '0; m_id_s1 = '0; m_id_rd = '0; m_ex_rd = '0; m_mem_rd = '0;
    m_ex_w = 1'b0; m_mem_w = 1'b0; m_id_i = -1;
    rst_n = 1'b1;
  endtask

  task automatic set_instr(input int i, input logic [1:0] k, input logic [4:0] rd,
                           input logic [4:0] s0, input logic [4:0] s1);
    p_cls[i] = k; p_rd[i] = rd; p_s0[i] = s0; p_s1[i] = s1;
  endtask

  task automatic model_step();
    logic hold, kill, bub, pch;
    hold = ifid_hold; kill = fetch_kill; bub = ex_bubble; pch = pc_hold;
    m_mem_v = m_ex_v; m_mem_k = m_ex_k; m_mem_rd = m_ex_rd; m_mem_w = m_ex_w;
    m_ex_v = m_id_v && !bub; m_ex_k = m_id_k; m_ex_rd = m_id_rd;
    m_ex_w = (m_id_k == A) || (m_id_k == L);
    if (!hold) begin
      if (kill || pc >= plen) begin
        m_id_v = 1'b0; m_id_i = -1; m_id_k = A;
        m_id_s0 = '0; m_id_s1 = '0; m_id_rd = '0;
      end else begin
        m_id_v = 1'b1; m_id_i = pc; m_id_k = p_cls[pc];
        m_id_s0 = p_s0[pc]; m_id_s1 = p_s1[pc]; m_id_rd = p_rd[pc];
      end
    end
    if (!pch) pc = pc + 1;
  endtask

  task automatic run_seq(input string req, input int n, input int exp_id [0:7]);
    model_reset();
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(req, $sformatf("decode occupant cycle %0d", k), m_id_i, exp_id[k]);
      model_step();
    end
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    use_model = 1'b1;
    plen = 0;
    model_reset();
    repeat (2) @(negedge clk);
    // reset state: empty pipeline gives free fetch, R8
    chk("R8", "reset outputs", int'({pc_hold, ifid_hold, ex_bubble, fetch_kill, gnt_if, gnt_mem}), 6'b000010);

    use_model = 1'b0;
    for (int i = 0; i < NT; i++) begin
      {t_id_vld, t_id_cls, t_s1, t_s0, t_ex_vld, t_ex_cls, t_ex_rd, t_ex_we,
       t_mem_vld, t_mem_cls, t_mem_rd, t_mem_we, t_exp} = TBL[i];
      @(negedge clk);
      chk($sformatf("R%0d", TREQ[i]), $sformatf("vector %0d", i),
          int'({pc_hold, ifid_hold, ex_bubble, fetch_kill, gnt_if, gnt_mem}), int'(t_exp));
    end

    use_model = 1'b1;
    // R4: load r1, dependent add, independent alu
    set_instr(0, L, 5'd1, 5'd0, 5'd0);
    set_instr(1, A, 5'd2, 5'd1, 5'd0);
    set_instr(2, A, 5'd3, 5'd0, 5'd0);
    plen = 3;
    run_seq("R4", 7, '{-1, 0, 1, 1, 1, 2, -1, -1});

    // R2: back-to-back stores lose fetch slots, decode keeps moving
    set_instr(0, S, 5'd0, 5'd1, 5'd2);
    set_instr(1, S, 5'd0, 5'd3, 5'd4);
    set_instr(2, A, 5'd3, 5'd0, 5'd0);
    set_instr(3, A, 5'd5, 5'd0, 5'd0);
    plen = 4;
    run_seq("R2", 7, '{-1, 0, 1, 2, -1, -1, 3, -1});

    // R7: branch followed by alu
    set_instr(0, B, 5'd0, 5'd0, 5'd0);
    set_instr(1, A, 5'd6, 5'd0, 5'd0);
    plen = 2;
    run_seq("R7", 6, '{-1, 0, -1, -1, 1, -1, -1, -1});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule